// File: doc/BRIEF.md
# TFT Panel Power-Up and Window Sequencer

This block is a hardware state machine that takes a small TFT display controller from power-up to the point where it accepts pixels. It drives the panel's hardware reset pin. It then emits a fixed list of controller commands and their arguments as tagged bytes for a downstream SPI serializer. The list wakes the controller and sets a 16-bit pixel format, default orientation and RGB order. It turns the display on and opens a drawing window over the visible 172 by 320 area.

The controller needs long pauses after its reset and after it leaves sleep. These pauses are counted in pulses of a millisecond tick input. Each pause counts one pulse more than its nominal length, so the real interval is never shorter than required. The visible panel sits inside a larger internal memory, so the window coordinates add a configurable column and row offset. The last command, memory write, leaves its frame open. The ready output then tells a pixel source that it may take over the byte stream.

Top module: `tft_init_seq`

## Requirements
- R1: After start is accepted, panel_rst_n is low for exactly 11 tick pulses (RST_LOW_MS+1). It is then high for exactly 121 tick pulses (RST_HIGH_MS+1) before the first byte is offered. No byte is offered while panel_rst_n is low.
- R2: The offered byte stream is, in order: 0x01, 0x11, 0x3A, 0x55, 0x36, 0x00, 0x29, 0x2A, four column bytes, 0x2B, four row bytes, 0x2C. That is 18 bytes in total.
- R3: The pixel-format command 0x3A carries the single data byte 0x55, and the access-control command 0x36 carries the single data byte 0x00.
- R4: The column bytes are, in order, the high and low bytes of col_off and then of col_off+171. The row bytes are the high and low bytes of row_off and then of row_off+319. All sums wrap modulo 2^16.
- R5: After the 0x01 byte is accepted, exactly 151 tick pulses pass before 0x11 is offered. After the 0x11 byte is accepted, exactly 121 pulses pass before 0x3A is offered. In each case the byte appears in the cycle after the last counted pulse.
- R6: out_is_data is 0 on command bytes and 1 on argument bytes. out_last is 1 on the final byte of every frame (0x01, 0x11, 0x55, 0x00, 0x29, the last column byte, the last row byte) and 0 on all other bytes, including 0x2C. A byte after a frame end is always a command.
- R7: While out_valid is high and out_ready is low, out_valid, out_byte, out_is_data and out_last hold their values. The stream advances only on an accepted byte.
- R8: ready rises in the cycle after the 0x2C byte is accepted and stays high until the next start. out_valid is low while ready is high.
- R9: start is ignored while a sequence is running. When the block is idle or ready, start restarts the full sequence from the reset pulse, and ready drops.
- R10: After rst_n is released, panel_rst_n is high and out_valid and ready are low until start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Begin the power-up sequence (sampled when idle or ready) |
| tick_ms | input | 1 | One-cycle pulse per millisecond |
| col_off | input | 16 | Column offset of the visible panel in controller memory |
| row_off | input | 16 | Row offset of the visible panel in controller memory |
| out_ready | input | 1 | Serializer accepts the offered byte |
| out_valid | output | 1 | A byte is offered |
| out_byte | output | 8 | Offered byte |
| out_is_data | output | 1 | 1 for an argument byte, 0 for a command byte |
| out_last | output | 1 | Byte closes its frame |
| panel_rst_n | output | 1 | Hardware reset pin of the panel, active low |
| ready | output | 1 | Memory-write frame is open for the pixel source |

## Verification
The assertions check the cycle-level rules on every clock. An offered byte holds steady under back-pressure. No byte is offered while the panel reset pin is low or after ready. A frame end is always followed by a command. ready rises only after a memory-write command is accepted. The bench's scenarios are needed for the rest: the exact byte order and argument values, window arithmetic with random and wrapping offsets, and the tick counts of the reset pulse and both controller pauses. They also show that a start during a running sequence is ignored and that a start after ready replays the whole list.

// File: rtl/tft_init_pkg.sv
package tft_init_pkg;

  localparam int STEP_N = 18;
  localparam int STEP_W = $clog2(STEP_N);

  localparam logic [7:0] OP_SOFT_RESET  = 8'h01;
  localparam logic [7:0] OP_SLEEP_EXIT  = 8'h11;
  localparam logic [7:0] OP_PIX_FORMAT  = 8'h3A;
  localparam logic [7:0] ARG_PIX_16BIT  = 8'h55;
  localparam logic [7:0] OP_ACCESS_CTRL = 8'h36;
  localparam logic [7:0] ARG_ACCESS_DEF = 8'h00;
  localparam logic [7:0] OP_DISPLAY_ON  = 8'h29;
  localparam logic [7:0] OP_COL_WINDOW  = 8'h2A;
  localparam logic [7:0] OP_ROW_WINDOW  = 8'h2B;
  localparam logic [7:0] OP_MEM_WRITE   = 8'h2C;

  typedef enum logic [2:0] {
    S_IDLE, S_RST_LO, S_RST_HI, S_SEND, S_WAIT, S_DONE
  } seq_state_e;

  typedef enum logic [1:0] {
    HOLD_NONE, HOLD_RESET, HOLD_WAKE
  } hold_e;

  typedef struct packed {
    logic [7:0] code;
    logic       is_data;
    logic       last;
    hold_e      hold;
    logic       final_step;
  } step_t;

endpackage

// File: rtl/tft_tick_timer.sv
module tft_tick_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             expire
);

  logic [CNT_W-1:0] cnt, cnt_nxt;
  logic             cnt_en;

  always_comb begin
    cnt_en  = load || (tick && (cnt != '0));
    cnt_nxt = load ? load_val : cnt - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_nxt;
  end

  assign expire = tick && (cnt == CNT_W'(1));

endmodule

// File: rtl/tft_step_table.sv
module tft_step_table
  import tft_init_pkg::*;
#(
  parameter int PANEL_W = 172,
  parameter int PANEL_H = 320
) (
  input  logic [STEP_W-1:0] idx,
  input  logic [15:0]       col_off,
  input  logic [15:0]       row_off,
  output step_t             step
);

  localparam logic [15:0] COL_SPAN = 16'(PANEL_W - 1);
  localparam logic [15:0] ROW_SPAN = 16'(PANEL_H - 1);

  logic [15:0] col_end, row_end;

  always_comb begin
    col_end = col_off + COL_SPAN;
    row_end = row_off + ROW_SPAN;
    step = '{code: 8'h00, is_data: 1'b1, last: 1'b0,
             hold: HOLD_NONE, final_step: 1'b0};
    case (int'(idx))
      0:  begin step.code = OP_SOFT_RESET;  step.is_data = 1'b0;
                step.last = 1'b1; step.hold = HOLD_RESET; end
      1:  begin step.code = OP_SLEEP_EXIT;  step.is_data = 1'b0;
                step.last = 1'b1; step.hold = HOLD_WAKE; end
      2:  begin step.code = OP_PIX_FORMAT;  step.is_data = 1'b0; end
      3:  begin step.code = ARG_PIX_16BIT;  step.last = 1'b1; end
      4:  begin step.code = OP_ACCESS_CTRL; step.is_data = 1'b0; end
      5:  begin step.code = ARG_ACCESS_DEF; step.last = 1'b1; end
      6:  begin step.code = OP_DISPLAY_ON;  step.is_data = 1'b0;
                step.last = 1'b1; end
      7:  begin step.code = OP_COL_WINDOW;  step.is_data = 1'b0; end
      8:  step.code = col_off[15:8];
      9:  step.code = col_off[7:0];
      10: step.code = col_end[15:8];
      11: begin step.code = col_end[7:0];  step.last = 1'b1; end
      12: begin step.code = OP_ROW_WINDOW;  step.is_data = 1'b0; end
      13: step.code = row_off[15:8];
      14: step.code = row_off[7:0];
      15: step.code = row_end[15:8];
      16: begin step.code = row_end[7:0];  step.last = 1'b1; end
      17: begin step.code = OP_MEM_WRITE;   step.is_data = 1'b0;
                step.final_step = 1'b1; end
      default: ;
    endcase
  end

endmodule

// File: rtl/tft_init_seq.sv
module tft_init_seq
  import tft_init_pkg::*;
#(
  parameter int PANEL_W     = 172,
  parameter int PANEL_H     = 320,
  parameter int RST_LOW_MS  = 10,
  parameter int RST_HIGH_MS = 120,
  parameter int SOFT_RST_MS = 150,
  parameter int WAKE_MS     = 120
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        tick_ms,
  input  logic [15:0] col_off,
  input  logic [15:0] row_off,
  input  logic        out_ready,
  output logic        out_valid,
  output logic [7:0]  out_byte,
  output logic        out_is_data,
  output logic        out_last,
  output logic        panel_rst_n,
  output logic        ready
);

  localparam int MAX_A = (RST_LOW_MS > RST_HIGH_MS) ? RST_LOW_MS : RST_HIGH_MS;
  localparam int MAX_B = (SOFT_RST_MS > WAKE_MS) ? SOFT_RST_MS : WAKE_MS;
  localparam int MAX_MS = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W  = $clog2(MAX_MS + 2);
  localparam logic [CNT_W-1:0] LD_RST_LO = CNT_W'(RST_LOW_MS + 1);
  localparam logic [CNT_W-1:0] LD_RST_HI = CNT_W'(RST_HIGH_MS + 1);
  localparam logic [CNT_W-1:0] LD_SOFT   = CNT_W'(SOFT_RST_MS + 1);
  localparam logic [CNT_W-1:0] LD_WAKE   = CNT_W'(WAKE_MS + 1);

  seq_state_e        state, state_nxt;
  logic [STEP_W-1:0] idx, idx_nxt;
  logic              idx_en;
  logic              tmr_load, tmr_expire;
  logic [CNT_W-1:0]  tmr_val;
  step_t             step;

  tft_step_table #(.PANEL_W(PANEL_W), .PANEL_H(PANEL_H)) u_table (
    .idx(idx), .col_off(col_off), .row_off(row_off), .step(step)
  );

  tft_tick_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .tick(tick_ms), .expire(tmr_expire)
  );

  always_comb begin
    state_nxt = state;
    idx_nxt   = idx;
    idx_en    = 1'b0;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    case (state)
      S_IDLE, S_DONE: begin
        if (start) begin
          state_nxt = S_RST_LO;
          idx_nxt   = '0;
          idx_en    = 1'b1;
          tmr_load  = 1'b1;
          tmr_val   = LD_RST_LO;
        end
      end
      S_RST_LO: begin
        if (tmr_expire) begin
          state_nxt = S_RST_HI;
          tmr_load  = 1'b1;
          tmr_val   = LD_RST_HI;
        end
      end
      S_RST_HI: if (tmr_expire) state_nxt = S_SEND;
      S_SEND: begin
        if (out_ready) begin
          if (step.final_step) begin
            state_nxt = S_DONE;
          end else begin
            idx_nxt = idx + STEP_W'(1);
            idx_en  = 1'b1;
            case (step.hold)
              HOLD_RESET: begin
                state_nxt = S_WAIT; tmr_load = 1'b1; tmr_val = LD_SOFT;
              end
              HOLD_WAKE: begin
                state_nxt = S_WAIT; tmr_load = 1'b1; tmr_val = LD_WAKE;
              end
              default: ;
            endcase
          end
        end
      end
      S_WAIT: if (tmr_expire) state_nxt = S_SEND;
      default: state_nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= state_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx <= '0;
    else if (idx_en) idx <= idx_nxt;
  end

  assign out_valid   = (state == S_SEND);
  assign out_byte    = step.code;
  assign out_is_data = step.is_data;
  assign out_last    = step.last;
  assign panel_rst_n = (state != S_RST_LO);
  assign ready       = (state == S_DONE);

endmodule

// File: rtl/tft_init_seq_chk.sv
module tft_init_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       out_ready,
  input logic       out_valid,
  input logic [7:0] out_byte,
  input logic       out_is_data,
  input logic       out_last,
  input logic       panel_rst_n,
  input logic       ready
);

  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_byte) && $stable(out_is_data) && $stable(out_last)));

  a_r1_silent_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !panel_rst_n |-> (!out_valid && !ready));

  a_r8_quiet_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !out_valid);

  a_r8_ready_after_memwr: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |->
      $past(out_valid && out_ready && !out_is_data && (out_byte == 8'h2C)));

  a_r6_cmd_after_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> (!out_valid || !out_is_data));

endmodule

bind tft_init_seq tft_init_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .out_ready(out_ready), .out_valid(out_valid),
  .out_byte(out_byte), .out_is_data(out_is_data), .out_last(out_last),
  .panel_rst_n(panel_rst_n), .ready(ready)
);

// File: tb/tft_init_seq_bench.sv
module tft_init_seq_bench;

  localparam int STEPS   = 18;
  localparam int T_LOW   = 11;
  localparam int T_HIGH  = 121;
  localparam int T_SOFT  = 151;
  localparam int T_WAKE  = 121;
  localparam int TICK_P  = 6;

  logic        clk = 1'b0;
  logic        rst_n, start, tick_ms, out_ready;
  logic [15:0] col_off, row_off;
  logic        out_valid, out_is_data, out_last, panel_rst_n, ready;
  logic [7:0]  out_byte;

  int nchk = 0, nerr = 0, cycles = 0, bp_pct = 100, tick_div = 0;
  bit wd_hit = 1'b0, mon_en = 1'b0;

  always #10 clk = ~clk;

  tft_init_seq u_tft_init_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .tick_ms(tick_ms),
    .col_off(col_off), .row_off(row_off), .out_ready(out_ready),
    .out_valid(out_valid), .out_byte(out_byte), .out_is_data(out_is_data),
    .out_last(out_last), .panel_rst_n(panel_rst_n), .ready(ready)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // {is_data, last, byte} expected at stream position p
  function automatic logic [9:0] exp_entry(input int p, input logic [15:0] c,
                                           input logic [15:0] r);
    logic [15:0] ce, re;
    ce = c + 16'd171;
    re = r + 16'd319;
    case (p)
      0:  return {2'b01, 8'h01};
      1:  return {2'b01, 8'h11};
      2:  return {2'b00, 8'h3A};
      3:  return {2'b11, 8'h55};
      4:  return {2'b00, 8'h36};
      5:  return {2'b11, 8'h00};
      6:  return {2'b01, 8'h29};
      7:  return {2'b00, 8'h2A};
      8:  return {2'b10, c[15:8]};
      9:  return {2'b10, c[7:0]};
      10: return {2'b10, ce[15:8]};
      11: return {2'b11, ce[7:0]};
      12: return {2'b00, 8'h2B};
      13: return {2'b10, r[15:8]};
      14: return {2'b10, r[7:0]};
      15: return {2'b10, re[15:8]};
      16: return {2'b11, re[7:0]};
      17: return {2'b00, 8'h2C};
      default: return 10'h3FF;
    endcase
  endfunction

  function automatic string req_of(input int p);
    if (p == 3 || p == 5) return "R3/R6 argument";
    if ((p >= 8 && p <= 11) || (p >= 13 && p <= 16)) return "R4/R6 window";
    return "R2/R6 order";
  endfunction

  // stimulus-side generators, driven 1 time unit after the edge
  always @(posedge clk) begin
    #1;
    cycles++;
    tick_div = (tick_div == TICK_P - 1) ? 0 : tick_div + 1;
    tick_ms = (tick_div == 0);
    out_ready = ($urandom_range(99) < bp_pct);
    if (cycles > 150000) wd_hit = 1'b1;
  end

  // monitor, sampled at the falling edge
  int pos = 0, phase = 0, tcnt = 0, texp = 0;
  bit expect_fall = 1'b0, prev_rst = 1'b1, hold_pend = 1'b0, chk_ready = 1'b0;
  logic [9:0] hold_val;

  always @(negedge clk) begin
    if (rst_n && mon_en) begin
      logic [9:0] got, exp;
      got = {out_is_data, out_last, out_byte};
      if (hold_pend) begin
        check(out_valid && (got == hold_val), "R7 hold under back-pressure",
              {21'd0, out_valid, got}, {21'd0, 1'b1, hold_val});
        hold_pend = 1'b0;
      end
      if (chk_ready) begin
        check(ready && !out_valid, "R8 ready after memory write",
              {30'd0, ready, out_valid}, 32'd2);
        chk_ready = 1'b0;
      end
      if (prev_rst && !panel_rst_n) begin
        check(expect_fall, "R9 restart while busy", 32'd1, {31'd0, expect_fall});
        check(!ready && !out_valid, "R9 ready drops on start",
              {30'd0, ready, out_valid}, 32'd0);
        expect_fall = 1'b0; phase = 1; tcnt = 0;
      end
      if (!prev_rst && panel_rst_n) begin
        check(tcnt == T_LOW, "R1 reset low ticks", tcnt, T_LOW);
        phase = 2; tcnt = 0; texp = T_HIGH;
      end
      if (out_valid && (phase == 2 || phase == 3)) begin
        check(tcnt == texp, (phase == 2) ? "R1 reset high ticks" : "R5 pause ticks",
              tcnt, texp);
        phase = 0;
      end
      if (phase != 0 && tick_ms) tcnt++;
      if (out_valid && out_ready) begin
        exp = exp_entry(pos, col_off, row_off);
        check(got == exp, req_of(pos), {22'd0, got}, {22'd0, exp});
        check(!ready, "R8 ready low while streaming", {31'd0, ready}, 32'd0);
        if (pos == 0) begin phase = 3; tcnt = 0; texp = T_SOFT; end
        if (pos == 1) begin phase = 3; tcnt = 0; texp = T_WAKE; end
        if (pos == STEPS - 1) chk_ready = 1'b1;
        pos++;
      end else if (out_valid) begin
        hold_pend = 1'b1;
        hold_val = got;
      end
      prev_rst = panel_rst_n;
    end
  end

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic run_seq(input logic [15:0] c, input logic [15:0] r,
                         input int bp, input bit poke);
    col_off = c; row_off = r; bp_pct = bp;
    pos = 0; expect_fall = 1'b1;
    cyc(); start = 1'b1;
    cyc(); start = 1'b0;
    if (poke) begin
      repeat (300) cyc();
      start = 1'b1; cyc(); start = 1'b0;   // R9: ignored mid-sequence
      repeat (1100) cyc();
      start = 1'b1; cyc(); start = 1'b0;   // R9: ignored during a pause
    end
    while (!ready && !wd_hit) cyc();
    repeat (4) cyc();
    check(pos == STEPS, "R2 byte count", pos, STEPS);
    check(ready && !out_valid, "R8 ready holds", {30'd0, ready, out_valid}, 32'd2);
  endtask

  initial begin
    void'($urandom(32'd5150));
    rst_n = 1'b0; start = 1'b0; tick_ms = 1'b0; out_ready = 1'b1;
    col_off = 16'd0; row_off = 16'd34;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) cyc();
    @(negedge clk);
    check(panel_rst_n, "R10 reset pin idle high", {31'd0, panel_rst_n}, 32'd1);
    check(!out_valid, "R10 no byte after reset", {31'd0, out_valid}, 32'd0);
    check(!ready, "R10 not ready after reset", {31'd0, ready}, 32'd0);
    mon_en = 1'b1;
    cyc();

    run_seq(16'd0, 16'd34, 100, 1'b0);                              // directed
    run_seq(16'($urandom_range(16'hFFFF)), 16'($urandom_range(16'hFFFF)),
            60, 1'b1);                                              // restart from ready
    run_seq(16'hFFF0, 16'hFFFF, 30, 1'b0);                          // R4 wrap
    run_seq(16'($urandom_range(300)), 16'($urandom_range(300)),
            10 + $urandom_range(80), 1'b1);

    if (wd_hit) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    end
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

endmodule